// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual page number into a physical frame number. It walks a tree of in-memory translation tables and issues one word read per tree level. A requester presents a virtual address. The walker reads one 8-byte entry at each level of the tree, starting from the table whose page frame number software has placed on the root input. It then returns the leaf frame number together with three permission bits, or it returns a fault if some level has no valid entry.

Two tree shapes are available. The first is a deep one: four levels, each indexed by 9 bits of a 48-bit virtual address. The second is a shallow one: two levels, each indexed by 10 bits of a 32-bit address. A software enable can turn translation off, and the address then passes straight through with no memory traffic. The block caches nothing and never writes memory. It keeps one walk in flight at a time and holds each result until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `mem_req_valid_o`, `done_o` and `fault_o` are 0.
- R2: With `walk_4lvl_i`=1 the walk reads four entries, indexed in order by virtual address bits 47:39, 38:30, 29:21 and 20:12, and issues no other read.
- R3: With `walk_4lvl_i`=0 the walk reads two entries, indexed in order by bits 31:22 and 21:12. Bits 47:32 have no effect.
- R4: Each entry address is the table base (frame number shifted left by 12) plus index times 8. The first table is `root_ppn_i`. Each later table is bits 39:12 of the parent entry.
- R5: Bit 0 of an entry is its present flag. A clear flag at any level ends the walk with `fault_o`=1, `frame_o`=0 and `perm_o`=0, and no further read is issued.
- R6: A present leaf gives `done_o`=1, `frame_o` = entry bits 39:12 and `perm_o` = entry bits 3:1.
- R7: With `xlate_en_i`=0 an accepted request completes with `done_o`=1, `frame_o` = address bits 39:12, `perm_o`=3'b111 and no memory read.
- R8: Virtual address bits 11:0 have no effect on the reads or the result.
- R9: A request is accepted only while `req_ready_o` is 1. `req_ready_o` is 0 for the whole walk, and a request presented during a walk is ignored.
- R10: `done_o` or `fault_o`, with `frame_o` and `perm_o`, stays unchanged until `ack_i` is sampled high. One cycle after that, the walker is idle again.
- R11: A memory request held while `mem_req_ready_i` is 0 keeps `mem_req_valid_o` high and its address unchanged.
- R12: `xlate_en_i`, `walk_4lvl_i` and `root_ppn_i` are sampled when a request is accepted. Changing them during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlate_en_i | input | 1 | 1 = translate, 0 = pass through |
| walk_4lvl_i | input | 1 | 1 = four 9-bit levels, 0 = two 10-bit levels |
| root_ppn_i | input | 28 | Frame number of the top-level table |
| req_valid_i | input | 1 | Translation request |
| req_vaddr_i | input | 48 | Virtual address of the request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle if valid |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_addr_o | output | 40 | Byte address of the entry |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry returned by memory |
| done_o | output | 1 | Translation complete, held until ack |
| fault_o | output | 1 | Walk hit a non-present entry, held until ack |
| frame_o | output | 28 | Translated frame number |
| perm_o | output | 3 | Permission bits of the leaf |
| ack_i | input | 1 | Requester has taken the result |

## Verification
The bench targets several corner cases. All-ones indices (511 and 1023) catch an index mask that is one bit short or a slice taken off by one level. In 2-level mode the upper address bits are set to nonzero values, which exposes a walker that takes indices from the 4-level positions. A 1023-entry index exposes one that ignores the carry past 4 KiB. Faults are forced at the first level, at the leaf, and on an entry whose present bit is clear but whose other bits are set; a design that tests the wrong bit or keeps reading would issue extra reads or return a stale frame. The memory ready line is toggled so that a request which drops or changes before its handshake is seen. A walk is also disturbed by a second request and by new mode, root and enable values, which a walker that samples them late would obey.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned PG_OFF_W    = 12;
  localparam int unsigned PTE_W       = 64;
  localparam int unsigned PTE_SHIFT   = 3;
  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned PERM_LSB    = 1;
  localparam int unsigned PERM_W      = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD
  } ptw_state_e;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel import ptw_pkg::*; #(
  parameter int unsigned VA_W     = 48,
  parameter int unsigned L4_LVLS  = 4,
  parameter int unsigned L4_IDX_W = 9,
  parameter int unsigned L2_LVLS  = 2,
  parameter int unsigned L2_IDX_W = 10,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned LVL_W    = 2
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             long_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx4 [L4_LVLS];
  logic [IDX_W-1:0] idx2 [L2_LVLS];
  logic             unused_offset;

  assign unused_offset = ^vaddr_i[PG_OFF_W-1:0];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < L4_LVLS; g++) begin : g_idx4
    assign idx4[g] = IDX_W'(vaddr_i[PG_OFF_W + (L4_LVLS-1-g)*L4_IDX_W +: L4_IDX_W]);
  end
  for (genvar g = 0; g < L2_LVLS; g++) begin : g_idx2
    assign idx2[g] = IDX_W'(vaddr_i[PG_OFF_W + (L2_LVLS-1-g)*L2_IDX_W +: L2_IDX_W]);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < L4_LVLS; i++) begin
      if (long_i && level_i == LVL_W'(i)) idx_o = idx4[i];
    end
    for (int i = 0; i < L2_LVLS; i++) begin
      if (!long_i && level_i == LVL_W'(i)) idx_o = idx2[i];
    end
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr import ptw_pkg::*; #(
  parameter int unsigned PA_W    = 40,
  parameter int unsigned FRAME_W = 28,
  parameter int unsigned IDX_W   = 10
) (
  input  logic [FRAME_W-1:0] base_frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PA_W-1:0]    addr_o
);
  // full add: a 1024-entry table spans two pages
  assign addr_o = {base_frame_i, {PG_OFF_W{1'b0}}} + (PA_W'(idx_i) << PTE_SHIFT);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; #(
  parameter int unsigned PA_W    = 40,
  parameter int unsigned FRAME_W = 28,
  parameter int unsigned VA_W    = 48,
  parameter int unsigned L4_LVLS = 4,
  parameter int unsigned L2_LVLS = 2,
  parameter int unsigned LVL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xlate_en_i,
  input  logic               walk_4lvl_i,
  input  logic [FRAME_W-1:0] root_ppn_i,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  output logic               req_ready_o,
  output logic [VA_W-1:0]    walk_vaddr_o,
  output logic               walk_long_o,
  output logic [LVL_W-1:0]   level_o,
  output logic [FRAME_W-1:0] base_frame_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  input  logic               mem_rsp_valid_i,
  input  logic [PTE_W-1:0]   mem_rsp_data_i,
  input  logic               ack_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [PERM_W-1:0]  perm_o
);
  ptw_state_e         state_q;
  logic [LVL_W-1:0]   level_q;
  logic [FRAME_W-1:0] base_q, frame_q;
  logic [PERM_W-1:0]  perm_q;
  logic [VA_W-1:0]    vaddr_q;
  logic               long_q, done_q, fault_q;

  logic               last_lvl, pte_present;
  logic [FRAME_W-1:0] pte_frame;
  logic [PERM_W-1:0]  pte_perm;
  logic               unused_pte_bits;

  assign pte_present = mem_rsp_data_i[PRESENT_BIT];
  assign pte_frame   = mem_rsp_data_i[PG_OFF_W +: FRAME_W];
  assign pte_perm    = mem_rsp_data_i[PERM_LSB +: PERM_W];
  assign unused_pte_bits = ^{mem_rsp_data_i[PTE_W-1:PG_OFF_W+FRAME_W],
                             mem_rsp_data_i[PG_OFF_W-1:PERM_LSB+PERM_W]};

  assign last_lvl = long_q ? (level_q == LVL_W'(L4_LVLS-1))
                           : (level_q == LVL_W'(L2_LVLS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      level_q <= '0;
      base_q  <= '0;
      frame_q <= '0;
      perm_q  <= '0;
      vaddr_q <= '0;
      long_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          long_q  <= walk_4lvl_i;
          level_q <= '0;
          base_q  <= root_ppn_i;
          if (xlate_en_i) begin
            state_q <= ST_ISSUE;
          end else begin
            done_q  <= 1'b1;
            frame_q <= FRAME_W'(req_vaddr_i >> PG_OFF_W);
            perm_q  <= '1;
            state_q <= ST_HOLD;
          end
        end
        ST_ISSUE: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!pte_present) begin
            fault_q <= 1'b1;
            frame_q <= '0;
            perm_q  <= '0;
            state_q <= ST_HOLD;
          end else if (last_lvl) begin
            done_q  <= 1'b1;
            frame_q <= pte_frame;
            perm_q  <= pte_perm;
            state_q <= ST_HOLD;
          end else begin
            base_q  <= pte_frame;
            level_q <= level_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_HOLD: if (ack_i) begin
          done_q  <= 1'b0;
          fault_q <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_ISSUE);
  assign walk_vaddr_o    = vaddr_q;
  assign walk_long_o     = long_q;
  assign level_o         = level_q;
  assign base_frame_o    = base_q;
  assign done_o          = done_q;
  assign fault_o         = fault_q;
  assign frame_o         = frame_q;
  assign perm_o          = perm_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; #(
  parameter int unsigned PA_W     = 40,
  parameter int unsigned L4_LVLS  = 4,
  parameter int unsigned L4_IDX_W = 9,
  parameter int unsigned L2_LVLS  = 2,
  parameter int unsigned L2_IDX_W = 10,
  parameter int unsigned VA_W     = PG_OFF_W + L4_LVLS*L4_IDX_W,
  parameter int unsigned FRAME_W  = PA_W - PG_OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xlate_en_i,
  input  logic               walk_4lvl_i,
  input  logic [FRAME_W-1:0] root_ppn_i,
  input  logic               req_valid_i,
  input  logic [VA_W-1:0]    req_vaddr_i,
  output logic               req_ready_o,
  output logic               mem_req_valid_o,
  output logic [PA_W-1:0]    mem_req_addr_o,
  input  logic               mem_req_ready_i,
  input  logic               mem_rsp_valid_i,
  input  logic [PTE_W-1:0]   mem_rsp_data_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [PERM_W-1:0]  perm_o,
  input  logic               ack_i
);
  localparam int unsigned MAX_LVLS = (L4_LVLS > L2_LVLS) ? L4_LVLS : L2_LVLS;
  localparam int unsigned LVL_W    = (MAX_LVLS > 1) ? $clog2(MAX_LVLS) : 1;
  localparam int unsigned IDX_W    = (L4_IDX_W > L2_IDX_W) ? L4_IDX_W : L2_IDX_W;

  logic [VA_W-1:0]    walk_vaddr;
  logic               walk_long;
  logic [LVL_W-1:0]   level;
  logic [FRAME_W-1:0] base_frame;
  logic [IDX_W-1:0]   idx;

  ptw_ctrl #(
    .PA_W(PA_W), .FRAME_W(FRAME_W), .VA_W(VA_W),
    .L4_LVLS(L4_LVLS), .L2_LVLS(L2_LVLS), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .xlate_en_i     (xlate_en_i),
    .walk_4lvl_i    (walk_4lvl_i),
    .root_ppn_i     (root_ppn_i),
    .req_valid_i    (req_valid_i),
    .req_vaddr_i    (req_vaddr_i),
    .req_ready_o    (req_ready_o),
    .walk_vaddr_o   (walk_vaddr),
    .walk_long_o    (walk_long),
    .level_o        (level),
    .base_frame_o   (base_frame),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .ack_i          (ack_i),
    .done_o         (done_o),
    .fault_o        (fault_o),
    .frame_o        (frame_o),
    .perm_o         (perm_o)
  );

  ptw_index_sel #(
    .VA_W(VA_W), .L4_LVLS(L4_LVLS), .L4_IDX_W(L4_IDX_W),
    .L2_LVLS(L2_LVLS), .L2_IDX_W(L2_IDX_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr_i(walk_vaddr),
    .long_i (walk_long),
    .level_i(level),
    .idx_o  (idx)
  );

  ptw_entry_addr #(
    .PA_W(PA_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_addr (
    .base_frame_i(base_frame),
    .idx_i       (idx),
    .addr_o      (mem_req_addr_o)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned PA_W     = 40,
  parameter int unsigned FRAME_W  = 28,
  parameter int unsigned MAX_LVLS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [PA_W-1:0]    mem_req_addr_o,
  input logic               done_o,
  input logic               fault_o,
  input logic [FRAME_W-1:0] frame_o,
  input logic [2:0]         perm_o,
  input logic               ack_i
);
  logic [7:0] reads_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reads_q <= '0;
    else if (req_valid_i && req_ready_o) reads_q <= '0;
    else if (mem_req_valid_o && mem_req_ready_i) reads_q <= reads_q + 1'b1;
  end

  a_r2_read_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_q <= 8'(MAX_LVLS));

  a_r4_entry_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

  a_r5_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!done_o && frame_o == '0 && perm_o == '0 && !mem_req_valid_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_valid_o && !done_o && !fault_o));

  a_r10_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> (done_o && $stable(frame_o) && $stable(perm_o)));

  a_r10_fault_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !ack_i) |=> fault_o);

  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_o || fault_o) && ack_i) |=> (!done_o && !fault_o && req_ready_o));

  a_r11_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
endmodule

bind pt_walker ptw_checker #(
  .PA_W(PA_W), .FRAME_W(FRAME_W), .MAX_LVLS(MAX_LVLS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .done_o         (done_o),
  .fault_o        (fault_o),
  .frame_o        (frame_o),
  .perm_o         (perm_o),
  .ack_i          (ack_i)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1, mode4 = 1'b1;
  logic [27:0] root = '0;
  logic        req_valid = 1'b0, ack = 1'b0;
  logic [47:0] req_vaddr = '0;
  logic        req_ready_o, mem_req_valid_o, done_o, fault_o;
  logic [39:0] mem_req_addr_o;
  logic [27:0] frame_o;
  logic [2:0]  perm_o;
  logic        rdy = 1'b1, rsp_valid = 1'b0, stall_en = 1'b0;
  logic [63:0] rsp_data = '0;

  logic [63:0] pmem [logic [39:0]];
  logic [39:0] exp_q [$];
  logic        exp_done, exp_fault;
  logic [27:0] exp_frame;
  logic [2:0]  exp_perm;
  logic [27:0] next_tbl = 28'h00200;
  string       cur_tag = "R1";
  int          n_chk = 0, n_fail = 0, cyc = 0;
  logic        hold_pend = 1'b0;
  logic [39:0] hold_addr;

  always #2 clk = ~clk;

  pt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xlate_en_i(xlate_en), .walk_4lvl_i(mode4),
    .root_ppn_i(root), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_ready_o(req_ready_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_ready_i(rdy),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .done_o(done_o), .fault_o(fault_o), .frame_o(frame_o), .perm_o(perm_o),
    .ack_i(ack)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [39:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  function automatic int idx_of(input logic [47:0] va, input bit long, input int l);
    if (long) return int'((va >> (12 + 9*(3-l))) & 48'h1FF);
    return int'((va >> (12 + 10*(1-l))) & 48'h3FF);
  endfunction

  function automatic logic [39:0] ent(input logic [27:0] base, input int idx);
    return {base, 12'h000} + 40'(idx) * 40'd8;
  endfunction

  function automatic logic [63:0] mk_pte(input logic [27:0] fr, input logic [2:0] pm);
    return (64'(fr) << 12) | (64'(pm) << 1) | 64'h1;
  endfunction

  task automatic map_va(input logic [27:0] rt, input logic [47:0] va, input bit long,
                        input logic [27:0] leaf, input logic [2:0] pm);
    logic [27:0] base = rt;
    int n = long ? 4 : 2;
    for (int l = 0; l < n; l++) begin
      logic [39:0] a = ent(base, idx_of(va, long, l));
      if (l == n-1) pmem[a] = mk_pte(leaf, pm);
      else begin
        if (!rd(a)[0]) begin
          pmem[a] = mk_pte(next_tbl, 3'b000);
          next_tbl = next_tbl + 28'd2;
        end
        base = rd(a)[39:12];
      end
    end
  endtask

  task automatic model(input logic [47:0] va);
    logic [27:0] base = root;
    int n = mode4 ? 4 : 2;
    exp_q.delete();
    exp_done = 0; exp_fault = 0; exp_frame = '0; exp_perm = '0;
    if (!xlate_en) begin
      exp_done = 1; exp_frame = va[39:12]; exp_perm = 3'b111;
      return;
    end
    for (int l = 0; l < n; l++) begin
      logic [39:0] a = ent(base, idx_of(va, mode4, l));
      logic [63:0] e = rd(a);
      exp_q.push_back(a);
      if (!e[0]) begin exp_fault = 1; return; end
      if (l == n-1) begin exp_done = 1; exp_frame = e[39:12]; exp_perm = e[3:1]; end
      else base = e[39:12];
    end
  endtask

  // memory model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= mem_req_valid_o && rdy;
    rsp_data  <= rd(mem_req_addr_o);
    rdy <= stall_en ? ~rdy : 1'b1;
  end

  // read monitor
  always @(negedge clk) if (rst_n) begin
    if (hold_pend) begin
      chk("R11", "stalled request kept", {23'b0, mem_req_valid_o, mem_req_addr_o}, {23'b0, 1'b1, hold_addr});
      hold_pend = 1'b0;
    end
    if (mem_req_valid_o) begin
      if (rdy) begin
        if (exp_q.size() == 0) chk(cur_tag, "unexpected read", 64'(mem_req_addr_o), 64'h0);
        else chk({cur_tag, " R4"}, "entry address", 64'(mem_req_addr_o), 64'(exp_q.pop_front()));
      end else begin
        hold_pend = 1'b1;
        hold_addr = mem_req_addr_o;
      end
    end
  end

  task automatic run(input logic [47:0] va, input string tag, input bit disturb);
    int w = 0;
    logic sv_en = xlate_en, sv_mode = mode4;
    logic [27:0] sv_root = root;
    cur_tag = tag;
    model(va);
    @(negedge clk);
    chk("R9", "ready before request", 64'(req_ready_o), 64'h1);
    req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin
      // R9 and R12: new request and new configuration mid-walk
      req_valid = 1'b1; req_vaddr = ~va;
      mode4 = ~mode4; xlate_en = ~xlate_en; root = root + 28'h40;
      chk("R9", "ready low while busy", 64'(req_ready_o), 64'h0);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!(done_o || fault_o) && w < 500) begin @(negedge clk); w++; end
    chk(tag, "done", 64'(done_o), 64'(exp_done));
    chk(tag, "fault", 64'(fault_o), 64'(exp_fault));
    chk(tag, "frame", 64'(frame_o), 64'(exp_frame));
    chk(tag, "perm", 64'(perm_o), 64'(exp_perm));
    chk(tag, "reads missing", 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk("R10", "result held", {62'b0, done_o, fault_o}, {62'b0, exp_done, exp_fault});
    chk("R10", "frame held", 64'(frame_o), 64'(exp_frame));
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R10", "cleared after ack", {61'b0, done_o, fault_o, req_ready_o}, 64'h1);
    xlate_en = sv_en; mode4 = sv_mode; root = sv_root;
  endtask

  // watchdog
  always @(negedge clk) if (cyc > 100000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [27:0] ROOT4 = 28'h00100;
  localparam logic [27:0] ROOT2 = 28'h00180;

  initial begin
    logic [47:0] va_a = {9'd5, 9'd17, 9'd300, 9'd511, 12'habc};
    logic [47:0] va_b = {9'd5, 9'd17, 9'd301, 9'd0, 12'h000};
    logic [47:0] va_c = {9'd511, 9'd511, 9'd511, 9'd511, 12'hfff};
    logic [47:0] va_s = {16'hDEAD, 10'd1023, 10'd1, 12'h123};
    map_va(ROOT4, va_a, 1'b1, 28'h00ABCDE, 3'b101);
    map_va(ROOT4, va_b, 1'b1, 28'h000F00D, 3'b011);
    map_va(ROOT4, va_c, 1'b1, 28'hFFFFFFF, 3'b111);
    map_va(ROOT2, va_s, 1'b0, 28'h0001234, 3'b100);
    pmem[ent(ROOT2, 5)] = 64'hFFFF_FFFE;  // frame bits set, present clear

    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", 64'(req_ready_o), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle outputs", {60'b0, req_ready_o, mem_req_valid_o, done_o, fault_o}, 64'h8);

    root = ROOT4; mode4 = 1'b1; xlate_en = 1'b1;
    run(va_a, "R2", 1'b0);
    run(va_b, "R6", 1'b0);
    run(va_c, "R6", 1'b0);
    run({va_a[47:12], 12'h000}, "R8", 1'b0);
    run({va_a[47:12], 12'hfff}, "R8", 1'b0);
    run({9'd6, 9'd17, 9'd300, 9'd511, 12'h0}, "R5", 1'b0);
    run({9'd5, 9'd17, 9'd300, 9'd7, 12'h0}, "R5", 1'b0);

    stall_en = 1'b1;
    run(va_a, "R11", 1'b0);
    run(va_a, "R12", 1'b1);

    root = ROOT2; mode4 = 1'b0;
    run(va_s, "R3", 1'b0);
    run({16'h0000, va_s[31:0]}, "R3", 1'b0);
    run({16'h0, 10'd1023, 10'd2, 12'h0}, "R5", 1'b0);
    run({16'h0, 10'd5, 10'd0, 12'h0}, "R5", 1'b0);
    run(va_s, "R12", 1'b1);
    stall_en = 1'b0;

    xlate_en = 1'b0;
    run(48'h3456_789A_BCDE, "R7", 1'b0);
    run(48'hFFFF_FFFF_F000, "R7", 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule